// File: doc/BRIEF.md
# Power-Down Clock Shutdown Sequencer

This block sits in the control core of a clock generator and runs on the internal CPU-rate clock. It takes an asynchronous, active-low power-down request and turns it into an ordered sequence. Every derived output clock is brought to its low level at one of its own falling transitions and held there. Only when all of them are held does the block drop the enables of the crystal oscillator and the PLL. On release it raises the oscillator enable first, then the PLL enable, and waits for a settle interval and for the PLL lock indication. The outputs then restart, each beginning with a complete high pulse.

The derived clocks are produced here by per-output dividers of the core clock: a differential CPU pair, a stoppable PCI clock, a free-running PCI clock, an AGP clock, a reference clock and a 48 MHz-class clock. Two further asynchronous active-low inputs halt the CPU pair and the stoppable PCI clock during normal running. The analog oscillator, PLL and pad drivers are outside the block and appear only as the two enables and the lock input.

Top module: `pwrdn_clk_sequencer`

## Requirements
- R1: After synchronous reset, osc_en and pll_en are 1, every single-ended clock output and cpu_clk_t are 0, and cpu_clk_c is 1; the outputs then start running without any further input.
- R2: pd_n, cpu_stop_n and pci_stop_n each pass through a two-stage synchronizer; osc_en stays 1 for at least four clock edges after pd_n is first sampled low.
- R3: cpu_clk_c is always the inverse of cpu_clk_t, so a parked CPU pair shows true low and complement high.
- R4: osc_en and pll_en fall together, and only once every output clock is low and held; while osc_en is 0 all outputs stay parked.
- R5: While power-down is in effect, cpu_stop_n and pci_stop_n have no effect on any output.
- R6: The reference and 48 MHz-class outputs park at their own next falling transition, which can take several core cycles; the oscillator is not switched off before they are parked.
- R7: On release of power-down, osc_en rises one cycle before pll_en.
- R8: Every high pulse of every output lasts exactly its configured half period, including the first pulse after a restart and the last pulse before a park.
- R9: If pd_n is reasserted while the block waits for lock, the enables drop again without any output toggling.
- R10: A power-down request that is released while outputs are still parking completes the shutdown and then restarts normally.
- R11: With cpu_stop_n low only the CPU pair parks (true low); with pci_stop_n low only the stoppable PCI clock parks, and the free-running PCI clock keeps toggling.
- R12: No output rises until at least SETTLE_CYCLES+1 cycles after pll_en rises and until pll_lock has been seen high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal CPU-rate core clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pd_n | input | 1 | Asynchronous power-down request, active low |
| cpu_stop_n | input | 1 | Asynchronous CPU pair halt, active low |
| pci_stop_n | input | 1 | Asynchronous stoppable PCI halt, active low |
| pll_lock | input | 1 | Lock indication from the PLL |
| osc_en | output | 1 | Crystal oscillator enable |
| pll_en | output | 1 | PLL/VCO enable |
| cpu_clk_t | output | 1 | CPU clock, true side |
| cpu_clk_c | output | 1 | CPU clock, complement side |
| pci_clk | output | 1 | Stoppable PCI clock |
| pci_free_clk | output | 1 | Free-running PCI clock |
| agp_clk | output | 1 | AGP clock |
| ref_clk | output | 1 | Reference clock |
| usb_clk | output | 1 | 48 MHz-class clock |

## Verification
A sequencer stuck in the wrong phase shows up at the ports within a few cycles: an enable that drops early leaves a clock high while osc_en is low, and a premature restart lets an output rise before the settle window has elapsed or while pll_lock is still low. A divider or gate that has lost its phase shows as a high pulse of the wrong length on the very next falling edge of that output. The bench model tracks every output and both enables on every cycle, so any divergence is reported in the cycle it first appears.

// File: rtl/pds_pkg.sv
// Package: shared types and helpers for the power-down sequencer.
// Assumes all users compile it first.
package pds_pkg;

    typedef enum logic [2:0] {
        ST_RUN         = 3'd0,
        ST_PARK        = 3'd1,
        ST_WAIT_PARKED = 3'd2,
        ST_OSC_OFF     = 3'd3,
        ST_OSC_ON      = 3'd4,
        ST_WAIT_LOCK   = 3'd5
    } seq_state_e;

    // Output channel indices, fixed order used by the top and the checker.
    localparam int NCH     = 6;
    localparam int CH_CPU  = 0;
    localparam int CH_PCI  = 1;
    localparam int CH_PCIF = 2;
    localparam int CH_AGP  = 3;
    localparam int CH_REF  = 4;
    localparam int CH_USB  = 5;

    // Width of a counter that must hold values 0..n-1 (at least one bit).
    function automatic int cnt_width(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/pds_sync.sv
// Module: multi-bit two-stage synchronizer for independent async
// active-low requests. Assumes each bit is a level, not a pulse;
// reset value is all ones (no request).
module pds_sync #(
    parameter int WIDTH = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_n,
    output logic [WIDTH-1:0] sync_n
);

    logic [WIDTH-1:0] stage1_q;
    logic [WIDTH-1:0] stage2_q;

    // Two flops per bit to settle metastability.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage1_q <= '1;
            stage2_q <= '1;
        end else begin
            stage1_q <= async_n;
            stage2_q <= stage1_q;
        end
    end

    assign sync_n = stage2_q;

endmodule

// File: rtl/pds_clk_chan.sv
// Module: one derived output clock. Divides the core clock by 2*HALF
// and gates the result so that it parks and restarts only in the low
// phase. Assumes run low holds the divider at phase 0; parked state is
// kept across a halt so a halted output stays low.
module pds_clk_chan
    import pds_pkg::*;
#(
    parameter int HALF = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic stop,
    output logic clk_o,
    output logic parked
);

    localparam int CW = cnt_width(HALF);
    localparam logic [CW-1:0] LAST = CW'(HALF - 1);

    logic [CW-1:0] cnt_q;
    logic          phase_q;
    logic          gated_q;
    logic          out_q;
    logic [CW-1:0] cnt_d;
    logic          phase_d;
    logic          gated_d;

    // Next divider count and phase; the phase flips when the count wraps.
    always_comb begin
        if (!run) begin
            cnt_d   = '0;
            phase_d = 1'b0;
        end else if (cnt_q == LAST) begin
            cnt_d   = '0;
            phase_d = ~phase_q;
        end else begin
            cnt_d   = cnt_q + 1'b1;
            phase_d = phase_q;
        end
    end

    // The gate may change only while the next phase is low.
    always_comb begin
        if (run && !phase_d) gated_d = stop;
        else                 gated_d = gated_q;
    end

    // Register divider, gate and the glitch-free output.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            phase_q <= 1'b0;
            gated_q <= 1'b1;
            out_q   <= 1'b0;
        end else begin
            cnt_q   <= cnt_d;
            phase_q <= phase_d;
            gated_q <= gated_d;
            out_q   <= run & phase_d & ~gated_d;
        end
    end

    assign clk_o  = out_q;
    assign parked = gated_q;

endmodule

// File: rtl/pds_seq_fsm.sv
// Module: power-down sequencing state machine. Parks outputs, removes
// oscillator and PLL enables, restores them in order and waits for a
// settle interval plus lock. Assumes pd_act is already synchronized.
module pds_seq_fsm
    import pds_pkg::*;
#(
    parameter int SETTLE_CYCLES = 24
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pd_act,
    input  logic all_parked,
    input  logic pll_lock,
    output logic stop_all,
    output logic div_run,
    output logic osc_en,
    output logic pll_en
);

    localparam int SW = $clog2(SETTLE_CYCLES + 1);
    localparam logic [SW-1:0] SETTLE_LOAD = SW'(SETTLE_CYCLES);

    seq_state_e    state_q;
    seq_state_e    state_d;
    logic [SW-1:0] settle_q;
    logic [SW-1:0] settle_d;

    // Next-state decision.
    always_comb begin
        state_d = state_q;
        case (state_q)
            ST_RUN:         if (pd_act) state_d = ST_PARK;
            ST_PARK:        state_d = ST_WAIT_PARKED;
            ST_WAIT_PARKED: if (all_parked) state_d = ST_OSC_OFF;
            ST_OSC_OFF:     if (!pd_act) state_d = ST_OSC_ON;
            ST_OSC_ON:      state_d = ST_WAIT_LOCK;
            ST_WAIT_LOCK: begin
                if (pd_act)                                state_d = ST_OSC_OFF;
                else if (settle_q == '0 && pll_lock)       state_d = ST_RUN;
            end
            default:        state_d = ST_PARK;
        endcase
    end

    // Settle counter: loaded when the oscillator restarts, counts down in lock wait.
    always_comb begin
        settle_d = settle_q;
        if (state_q == ST_OSC_ON)                           settle_d = SETTLE_LOAD;
        else if (state_q == ST_WAIT_LOCK && settle_q != '0) settle_d = settle_q - 1'b1;
    end

    // State and counter registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= ST_RUN;
            settle_q <= '0;
        end else begin
            state_q  <= state_d;
            settle_q <= settle_d;
        end
    end

    assign stop_all = (state_q != ST_RUN);
    assign div_run  = (state_q == ST_RUN) || (state_q == ST_PARK)
                   || (state_q == ST_WAIT_PARKED);
    assign osc_en   = (state_q != ST_OSC_OFF);
    assign pll_en   = div_run || (state_q == ST_WAIT_LOCK);

endmodule

// File: rtl/pwrdn_clk_sequencer.sv
// Module: top of the power-down clock shutdown sequencer. Synchronizes
// the three async requests, runs the sequencing FSM and drives six
// gated divider channels. Assumes clk is the internal CPU-rate clock
// and the oscillator/PLL are external, seen only through osc_en,
// pll_en and pll_lock.
module pwrdn_clk_sequencer
    import pds_pkg::*;
#(
    parameter int CPU_HALF      = 1,
    parameter int PCI_HALF      = 4,
    parameter int AGP_HALF      = 2,
    parameter int REF_HALF      = 9,
    parameter int USB_HALF      = 3,
    parameter int SETTLE_CYCLES = 24
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pd_n,
    input  logic cpu_stop_n,
    input  logic pci_stop_n,
    input  logic pll_lock,
    output logic osc_en,
    output logic pll_en,
    output logic cpu_clk_t,
    output logic cpu_clk_c,
    output logic pci_clk,
    output logic pci_free_clk,
    output logic agp_clk,
    output logic ref_clk,
    output logic usb_clk
);

    localparam int unsigned HALVES [NCH] = '{CPU_HALF, PCI_HALF, PCI_HALF,
                                             AGP_HALF, REF_HALF, USB_HALF};

    logic [2:0]     req_sync_n;
    logic           pd_act;
    logic           cpu_hold;
    logic           pci_hold;
    logic           stop_all;
    logic           div_run;
    logic           all_parked;
    logic [NCH-1:0] ch_stop;
    logic [NCH-1:0] ch_clk;
    logic [NCH-1:0] ch_parked;

    pds_sync #(.WIDTH(3)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_n ({pci_stop_n, cpu_stop_n, pd_n}),
        .sync_n  (req_sync_n)
    );

    assign pd_act   = ~req_sync_n[0];
    assign cpu_hold = ~req_sync_n[1];
    assign pci_hold = ~req_sync_n[2];

    pds_seq_fsm #(.SETTLE_CYCLES(SETTLE_CYCLES)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .pd_act     (pd_act),
        .all_parked (all_parked),
        .pll_lock   (pll_lock),
        .stop_all   (stop_all),
        .div_run    (div_run),
        .osc_en     (osc_en),
        .pll_en     (pll_en)
    );

    // Per-channel stop: power-down overrides the individual halts.
    always_comb begin
        ch_stop          = {NCH{stop_all}};
        ch_stop[CH_CPU]  = stop_all | cpu_hold;
        ch_stop[CH_PCI]  = stop_all | pci_hold;
    end

    genvar gi;
    generate
        for (gi = 0; gi < NCH; gi++) begin : g_chan
            pds_clk_chan #(.HALF(int'(HALVES[gi]))) u_chan (
                .clk    (clk),
                .rst_n  (rst_n),
                .run    (div_run),
                .stop   (ch_stop[gi]),
                .clk_o  (ch_clk[gi]),
                .parked (ch_parked[gi])
            );
        end
    endgenerate

    assign all_parked   = &ch_parked;
    assign cpu_clk_t    = ch_clk[CH_CPU];
    assign cpu_clk_c    = ~ch_clk[CH_CPU];
    assign pci_clk      = ch_clk[CH_PCI];
    assign pci_free_clk = ch_clk[CH_PCIF];
    assign agp_clk      = ch_clk[CH_AGP];
    assign ref_clk      = ch_clk[CH_REF];
    assign usb_clk      = ch_clk[CH_USB];

endmodule

// File: rtl/pds_checker.sv
// Module: port-level assertion checker for the sequencer, bound to the
// top. Assumes the same channel halves and settle count as the top.
module pds_checker
    import pds_pkg::*;
#(
    parameter int CPU_HALF      = 1,
    parameter int PCI_HALF      = 4,
    parameter int AGP_HALF      = 2,
    parameter int REF_HALF      = 9,
    parameter int USB_HALF      = 3,
    parameter int SETTLE_CYCLES = 24
) (
    input logic clk,
    input logic rst_n,
    input logic osc_en,
    input logic pll_en,
    input logic cpu_clk_t,
    input logic cpu_clk_c,
    input logic pci_clk,
    input logic pci_free_clk,
    input logic agp_clk,
    input logic ref_clk,
    input logic usb_clk
);

    localparam int unsigned HALVES [NCH] = '{CPU_HALF, PCI_HALF, PCI_HALF,
                                             AGP_HALF, REF_HALF, USB_HALF};
    localparam int CAP = SETTLE_CYCLES + 2;
    localparam int KW  = $clog2(CAP + 1);

    logic [NCH-1:0] outs;
    logic           any_out;
    logic [KW-1:0]  wake_cnt;

    assign outs    = {usb_clk, ref_clk, agp_clk, pci_free_clk, pci_clk, cpu_clk_t};
    assign any_out = |outs;

    // Cycles since pll_en rose, saturating; starts saturated after reset.
    always_ff @(posedge clk) begin
        if (!rst_n)                   wake_cnt <= KW'(CAP);
        else if (!pll_en)             wake_cnt <= '0;
        else if (wake_cnt != KW'(CAP)) wake_cnt <= wake_cnt + 1'b1;
    end

    // R4: with the oscillator off every output is parked.
    p_parked_while_off_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !osc_en |-> (outs == '0 && cpu_clk_c));

    // R4: the PLL enable never drops while the oscillator stays on.
    p_enables_drop_together_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pll_en) |-> !osc_en);

    // R7: the oscillator is already enabled when the PLL enable rises.
    p_osc_before_pll_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pll_en) |-> $past(osc_en));

    // R12: no output restarts inside the settle window.
    p_settle_before_release_r12: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(any_out) |-> (wake_cnt >= KW'(SETTLE_CYCLES + 1)));

    genvar gi;
    generate
        for (gi = 0; gi < NCH; gi++) begin : g_width
            logic [15:0] hi_cnt;

            // Length of the current high run of this output.
            always_ff @(posedge clk) begin
                if (!rst_n)        hi_cnt <= '0;
                else if (outs[gi]) hi_cnt <= hi_cnt + 1'b1;
                else               hi_cnt <= '0;
            end

            // R8: each high pulse is exactly the configured half period.
            p_full_high_r8: assert property (@(posedge clk) disable iff (!rst_n)
                $fell(outs[gi]) |-> (hi_cnt == 16'(HALVES[gi])));
        end
    endgenerate

endmodule

bind pwrdn_clk_sequencer pds_checker #(
    .CPU_HALF      (CPU_HALF),
    .PCI_HALF      (PCI_HALF),
    .AGP_HALF      (AGP_HALF),
    .REF_HALF      (REF_HALF),
    .USB_HALF      (USB_HALF),
    .SETTLE_CYCLES (SETTLE_CYCLES)
) u_pds_checker (
    .clk          (clk),
    .rst_n        (rst_n),
    .osc_en       (osc_en),
    .pll_en       (pll_en),
    .cpu_clk_t    (cpu_clk_t),
    .cpu_clk_c    (cpu_clk_c),
    .pci_clk      (pci_clk),
    .pci_free_clk (pci_free_clk),
    .agp_clk      (agp_clk),
    .ref_clk      (ref_clk),
    .usb_clk      (usb_clk)
);

// File: tb/tb_pwrdn_clk_sequencer.sv
// Bench: behavioural cycle model compared on every clock, plus directed
// scenario checks for each requirement.
module tb_pwrdn_clk_sequencer;

    localparam int SETTLE = 24;
    localparam int HV [6] = '{1, 4, 4, 2, 9, 3};

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic pd_n = 1'b1;
    logic cpu_stop_n = 1'b1;
    logic pci_stop_n = 1'b1;
    logic pll_lock = 1'b0;
    logic osc_en, pll_en, cpu_clk_t, cpu_clk_c, pci_clk, pci_free_clk;
    logic agp_clk, ref_clk, usb_clk;

    int checks = 0;
    int fails = 0;
    int cycles = 0;
    int lock_delay = 5;
    int lk_cnt = 0;
    bit cmp_en = 1'b0;

    always #4 clk = ~clk;

    pwrdn_clk_sequencer #(
        .CPU_HALF(1), .PCI_HALF(4), .AGP_HALF(2), .REF_HALF(9), .USB_HALF(3),
        .SETTLE_CYCLES(SETTLE)
    ) dut (
        .clk(clk), .rst_n(rst_n), .pd_n(pd_n), .cpu_stop_n(cpu_stop_n),
        .pci_stop_n(pci_stop_n), .pll_lock(pll_lock), .osc_en(osc_en),
        .pll_en(pll_en), .cpu_clk_t(cpu_clk_t), .cpu_clk_c(cpu_clk_c),
        .pci_clk(pci_clk), .pci_free_clk(pci_free_clk), .agp_clk(agp_clk),
        .ref_clk(ref_clk), .usb_clk(usb_clk)
    );

    function automatic logic [5:0] outv();
        return {usb_clk, ref_clk, agp_clk, pci_free_clk, pci_clk, cpu_clk_t};
    endfunction

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d at cycle %0d", tag, act, exp, cycles);
        end
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    // PLL stand-in: lock rises lock_delay cycles after pll_en.
    always @(negedge clk) begin
        if (!pll_en) begin
            lk_cnt = 0;
            pll_lock <= 1'b0;
        end else begin
            if (lk_cnt < lock_delay) lk_cnt++;
            pll_lock <= (lk_cnt >= lock_delay);
        end
    end

    // ---------------- behavioural reference model ----------------
    // Modes: 0 running, 1 stop issued, 2 waiting for parks, 3 off,
    // 4 oscillator back, 5 waiting for settle and lock.
    int m_mode = 0;
    int m_settle = 0;
    bit m_pd[$], m_cs[$], m_ps[$];
    int m_tick [6];
    bit m_ph [6];
    bit m_gate [6];
    bit m_o [6];

    always @(posedge clk) begin
        if (!rst_n) begin
            m_mode = 0; m_settle = 0;
            m_pd = '{1'b1, 1'b1}; m_cs = '{1'b1, 1'b1}; m_ps = '{1'b1, 1'b1};
            for (int i = 0; i < 6; i++) begin
                m_tick[i] = 0; m_ph[i] = 0; m_gate[i] = 1; m_o[i] = 0;
            end
        end else begin
            bit pd_req, cs_req, ps_req, running, parked_all;
            int nmode;
            pd_req = !m_pd[0]; cs_req = !m_cs[0]; ps_req = !m_ps[0];
            running = (m_mode <= 2);
            parked_all = 1;
            for (int i = 0; i < 6; i++) parked_all &= m_gate[i];
            nmode = m_mode;
            case (m_mode)
                0: if (pd_req) nmode = 1;
                1: nmode = 2;
                2: if (parked_all) nmode = 3;
                3: if (!pd_req) nmode = 4;
                4: begin nmode = 5; m_settle = SETTLE; end
                default: begin
                    if (pd_req) nmode = 3;
                    else if (m_settle == 0 && pll_lock) nmode = 0;
                    else if (m_settle > 0) m_settle--;
                end
            endcase
            for (int i = 0; i < 6; i++) begin
                bit stp;
                stp = (m_mode != 0) || (i == 0 && cs_req) || (i == 1 && ps_req);
                if (!running) begin
                    m_tick[i] = 0; m_ph[i] = 0; m_o[i] = 0;
                end else begin
                    if (m_tick[i] == HV[i] - 1) begin m_tick[i] = 0; m_ph[i] = !m_ph[i]; end
                    else m_tick[i]++;
                    if (!m_ph[i]) m_gate[i] = stp;
                    m_o[i] = m_ph[i] && !m_gate[i];
                end
            end
            m_mode = nmode;
            void'(m_pd.pop_front()); m_pd.push_back(pd_n);
            void'(m_cs.pop_front()); m_cs.push_back(cpu_stop_n);
            void'(m_ps.pop_front()); m_ps.push_back(pci_stop_n);
        end
    end

    // Per-cycle comparison of every output with the model.
    always @(negedge clk) begin
        cycles++;
        if (cmp_en) begin
            string tags [6];
            bit m_osc, m_pll;
            tags = '{"R3", "R11", "R8", "R8", "R6", "R6"};
            m_osc = (m_mode != 3);
            m_pll = (m_mode <= 2) || (m_mode == 5);
            for (int i = 0; i < 6; i++)
                chk(outv()[i] == m_o[i], tags[i], outv()[i], m_o[i]);
            chk(cpu_clk_c == !m_o[0], "R3", cpu_clk_c, !m_o[0]);
            chk(osc_en == m_osc, "R4", osc_en, m_osc);
            chk(pll_en == m_pll, "R7", pll_en, m_pll);
        end
        if (cycles > 150000) begin
            fails++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", cycles, 150000);
            finish_run();
        end
    end

    // Wait at negedges until a selected signal reaches val.
    // which: 0 osc_en, 1 pll_en, 2 any output high.
    task automatic wait_for(input int which, input bit val, input int limit,
                            output int n, output bit found);
        n = 0; found = 0;
        while (n < limit && !found) begin
            @(negedge clk);
            n++;
            case (which)
                0: found = (osc_en == val);
                1: found = (pll_en == val);
                default: found = ((|outv()) == val);
            endcase
        end
    endtask

    task automatic count_rises(input int len, output int cpu_r, output int pci_r,
                               output int pcif_r, output bit cpu_hi, output bit pci_hi);
        logic [5:0] prev;
        cpu_r = 0; pci_r = 0; pcif_r = 0; cpu_hi = 0; pci_hi = 0;
        prev = outv();
        for (int k = 0; k < len; k++) begin
            @(negedge clk);
            if (outv()[0] && !prev[0]) cpu_r++;
            if (outv()[1] && !prev[1]) pci_r++;
            if (outv()[2] && !prev[2]) pcif_r++;
            cpu_hi |= outv()[0] | !cpu_clk_c;
            pci_hi |= outv()[1];
            prev = outv();
        end
    endtask

    initial begin
        int n, cr, pr, fr;
        bit f, ch, ph, seen_hi, seen_off;
        repeat (2) @(posedge clk);
        @(negedge clk);
        cmp_en = 1'b1;
        repeat (2) @(negedge clk);
        // R1 reset state
        chk(osc_en && pll_en, "R1", {osc_en, pll_en}, 3);
        chk(outv() == 6'd0, "R1", outv(), 0);
        chk(cpu_clk_c == 1'b1, "R1", cpu_clk_c, 1);
        rst_n = 1'b1;
        count_rises(64, cr, pr, fr, ch, ph);
        chk(pr >= 6, "R8", pr, 6);
        chk(cr >= 28, "R1", cr, 28);

        // R11 CPU halt
        cpu_stop_n = 1'b0;
        repeat (6) @(negedge clk);
        count_rises(40, cr, pr, fr, ch, ph);
        chk(!ch, "R11", ch, 0);
        chk(pr >= 4, "R11", pr, 4);
        cpu_stop_n = 1'b1;
        repeat (6) @(negedge clk);
        count_rises(20, cr, pr, fr, ch, ph);
        chk(cr >= 8, "R11", cr, 8);

        // R11 PCI halt
        pci_stop_n = 1'b0;
        repeat (12) @(negedge clk);
        count_rises(40, cr, pr, fr, ch, ph);
        chk(!ph, "R11", ph, 0);
        chk(fr >= 4, "R11", fr, 4);
        pci_stop_n = 1'b1;
        repeat (12) @(negedge clk);

        // Shutdown with early lock
        lock_delay = 5;
        pd_n = 1'b0;
        repeat (4) @(negedge clk);
        chk(osc_en == 1'b1, "R2", osc_en, 1);
        wait_for(0, 1'b0, 80, n, f);
        chk(f, "R4", f, 1);
        chk(n + 4 >= 6 && n + 4 <= 6 + 2 * 9 + 4, "R6", n + 4, 6);
        chk(outv() == 6'd0 && cpu_clk_c, "R3", outv(), 0);
        for (int k = 0; k < 20; k++) begin
            cpu_stop_n = k[0]; pci_stop_n = k[1];
            @(negedge clk);
            chk(outv() == 6'd0 && cpu_clk_c, "R5", outv(), 0);
        end
        cpu_stop_n = 1'b1; pci_stop_n = 1'b1;
        repeat (3) @(negedge clk);
        pd_n = 1'b1;
        wait_for(0, 1'b1, 20, n, f);
        chk(f && !pll_en, "R7", pll_en, 0);
        @(negedge clk);
        chk(pll_en == 1'b1, "R7", pll_en, 1);
        wait_for(2, 1'b1, 300, n, f);
        chk(f && n >= SETTLE + 1, "R12", n, SETTLE + 1);
        repeat (40) @(negedge clk);

        // Shutdown with late lock
        lock_delay = 60;
        pd_n = 1'b0;
        wait_for(0, 1'b0, 80, n, f);
        repeat (5) @(negedge clk);
        pd_n = 1'b1;
        wait_for(1, 1'b1, 20, n, f);
        n = 0; seen_hi = 0;
        while (!(|outv()) && n < 300) begin
            @(negedge clk);
            n++;
            seen_hi = (|outv()) && !pll_lock;
        end
        chk(n >= 60, "R12", n, 60);
        chk(!seen_hi, "R12", seen_hi, 0);
        repeat (40) @(negedge clk);

        // R9 reassert during lock wait
        lock_delay = 5;
        pd_n = 1'b0;
        wait_for(0, 1'b0, 80, n, f);
        pd_n = 1'b1;
        wait_for(1, 1'b1, 20, n, f);
        pd_n = 1'b0;
        seen_hi = 0; seen_off = 0;
        for (int k = 0; k < 40; k++) begin
            @(negedge clk);
            seen_hi |= (|outv());
            seen_off |= !osc_en;
        end
        chk(!seen_hi, "R9", seen_hi, 0);
        chk(seen_off && !pll_en, "R9", seen_off, 1);
        pd_n = 1'b1;
        wait_for(2, 1'b1, 300, n, f);
        chk(f, "R9", f, 1);
        repeat (30) @(negedge clk);

        // R10 short request
        pd_n = 1'b0;
        repeat (3) @(negedge clk);
        pd_n = 1'b1;
        wait_for(0, 1'b0, 60, n, f);
        chk(f, "R10", f, 1);
        wait_for(2, 1'b1, 300, n, f);
        chk(f && osc_en && pll_en, "R10", f, 1);
        repeat (30) @(negedge clk);

        finish_run();
    end

endmodule